// File: doc/BRIEF.md
# Clear-Only Flash Block Protection Registers

This block holds the per-block access permissions of an on-chip flash array. It has two 32-bit permission registers. One grants read access and the other grants program access. Each bit covers one 2-KB flash block, so each register spans 64 KB. Software can only revoke a permission: a write ANDs the written data into the current value, so a 0 in the data clears a bit and a 1 leaves it as it is. No write can set a bit back to 1.

A revoked permission is at first only temporary. A keyed commit command copies the current value into a persistent copy, which stands in for non-volatile storage. That copy also only loses bits; commit stores persistent AND current. While power-on reset is held, the live registers reload from the persistent copy, so any clear that was not committed is lost. A warm reset leaves the live registers alone and only drops any pending read response. A separate factory-init input sets the persistent copy to all ones, the open state. The live registers drive the per-block permission outputs directly.

Reads use a simple request/response scheme. A `bus_rd` pulse gives a `rsp_valid` pulse exactly one cycle later, carrying the data. There is no back-pressure: the requester must take every response in the cycle it appears. Writes take effect at the clock edge where `bus_wr` is sampled. If a read and a write fall in the same cycle, the read returns the value from before the write.

Top module: `flash_guard_regs`

## Requirements
- R1: After factory init plus power-on reset, both permission registers read 0xFFFFFFFF.
- R2: A write to a permission register stores old AND wdata; a bit that is 0 never returns to 1 through any write.
- R3: Offsets 0x130 and 0x200 both reach the read-permission register, and offsets 0x134 and 0x400 both reach the program-permission register; each alias pair shares one storage.
- R4: A write to one register's addresses leaves the other register unchanged.
- R5: A write to offset 0x0F0 with wdata[31:16]=0x5A17 is a commit. Bit 0 selects the read-permission register and bit 1 selects the program-permission register. After a later power-on reset, each selected register reloads its value from the moment of the commit.
- R6: Clears that were never committed are undone by power-on reset, which reloads the last committed value.
- R7: A commit write whose key field is not 0x5A17 changes no persistent value.
- R8: Warm reset keeps both live registers and forces `rsp_valid` low.
- R9: `rsp_valid` goes high for exactly one cycle, the cycle after `bus_rd`. A read of offset 0x0F0 or of any unmapped offset returns 0.
- R10: `rd_allow` and `pg_allow` always equal the current read-permission and program-permission registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; reloads live registers from the persistent copy |
| warm_rst_n | input | 1 | Warm reset, active low; clears only the read response |
| factory_n | input | 1 | Factory init, active low; sets the persistent copy to all ones |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the request |
| rsp_data | output | 32 | Read response data |
| rd_allow | output | 32 | Per-block read permission |
| pg_allow | output | 32 | Per-block program permission |

## Verification
The bench goes after four things. The first is a write of all ones after a clear: a design that stores the write data directly would bring the revoked bit back. The second is an alias that does not share storage, which would show a stale value at the other offset. Power-on reset is tested both after a wrong-key commit and after a correct one. A design with no key check would keep the clears, and a design that reloads from the wrong place would either lose the committed clears or keep the uncommitted ones. Warm reset is placed between clears to catch a design that reloads on every reset. Random sparse-zero writes, aliases, commits and power-on resets are then checked against a bench model.

// File: rtl/flg_pkg.sv
package flg_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NREG   = 2;
  localparam logic [ADDR_W-1:0] OFS_RD_A = 12'h130;
  localparam logic [ADDR_W-1:0] OFS_RD_B = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_PG_A = 12'h134;
  localparam logic [ADDR_W-1:0] OFS_PG_B = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_CMT  = 12'h0F0;
  localparam logic [15:0]       CMT_KEY  = 16'h5A17;
  typedef enum logic [1:0] {SEL_NONE, SEL_RD, SEL_PG, SEL_CMT} sel_e;
endpackage

// File: rtl/flg_decode.sv
module flg_decode
  import flg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output sel_e              sel,
  output logic              key_ok
);
  always_comb begin
    unique case (addr)
      OFS_RD_A, OFS_RD_B: sel = SEL_RD;
      OFS_PG_A, OFS_PG_B: sel = SEL_PG;
      OFS_CMT:            sel = SEL_CMT;
      default:            sel = SEL_NONE;
    endcase
  end
  assign key_ok = (wdata[DATA_W-1 -: 16] == CMT_KEY);
endmodule

// File: rtl/flg_clrreg.sv
module flg_clrreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         factory_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         cmt_en,
  output logic [W-1:0] live
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] live_q;

  always_ff @(posedge clk) begin
    if (!factory_n)  shadow_q <= '1;
    else if (cmt_en) shadow_q <= shadow_q & live_q;
  end

  always_ff @(posedge clk) begin
    if (!por_n)     live_q <= shadow_q;
    else if (wr_en) live_q <= live_q & wdata;
  end

  assign live = live_q;

  AST_LIVE_NO_SET: assert property (@(posedge clk) disable iff (!por_n)
    $past(por_n) |-> ((live_q & ~$past(live_q)) == '0)); // R2
  AST_SHADOW_NO_SET: assert property (@(posedge clk) disable iff (!factory_n)
    $past(factory_n) |-> ((shadow_q & ~$past(shadow_q)) == '0)); // R5
  AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable(live_q)); // R8
endmodule

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flg_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic              factory_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] rd_allow,
  output logic [DATA_W-1:0] pg_allow
);
  localparam sel_e REG_SEL [NREG] = '{SEL_RD, SEL_PG};

  sel_e              sel;
  logic              key_ok;
  logic [DATA_W-1:0] live [NREG];
  logic [DATA_W-1:0] rd_mux;

  flg_decode u_dec (
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .sel    (sel),
    .key_ok (key_ok)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wr_g, cmt_g;
    assign wr_g  = bus_wr && (sel == REG_SEL[g]);
    assign cmt_g = bus_wr && (sel == SEL_CMT) && key_ok && bus_wdata[g];
    flg_clrreg #(.W(DATA_W)) u_reg (
      .clk       (clk),
      .por_n     (por_n),
      .factory_n (factory_n),
      .wr_en     (wr_g),
      .wdata     (bus_wdata),
      .cmt_en    (cmt_g),
      .live      (live[g])
    );
  end

  assign rd_allow = live[0];
  assign pg_allow = live[1];

  always_comb begin
    unique case (sel)
      SEL_RD:  rd_mux = live[0];
      SEL_PG:  rd_mux = live[1];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n || !warm_rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= bus_rd;
      if (bus_rd) rsp_data <= rd_mux;
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    bus_rd |=> rsp_valid); // R9
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!por_n || !warm_rst_n)
    !bus_rd |=> !rsp_valid); // R9
endmodule

// File: tb/sim_flash_guard_regs.sv
module sim_flash_guard_regs;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, warm_rst_n = 1'b0, factory_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data, rd_allow, pg_allow;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_rd, m_pg, s_rd, s_pg;

  always #10 clk = ~clk;

  flash_guard_regs u0 (.*);

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] w);
    return old & w;
  endfunction

  function automatic logic [31:0] sparse();
    return $urandom | $urandom | $urandom;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 12'h130 || a == 12'h200) m_rd = merge(m_rd, d);
    if (a == 12'h134 || a == 12'h400) m_pg = merge(m_pg, d);
    if (a == 12'h0F0 && d[31:16] == 16'h5A17) begin
      if (d[0]) s_rd = merge(s_rd, m_rd);
      if (d[1]) s_pg = merge(s_pg, m_pg);
    end
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check({tag, " R9 valid"}, {31'd0, rsp_valid}, 32'd1);
    check(tag, rsp_data, exp);
    @(negedge clk);
    check({tag, " R9 one-cycle"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic outs(input string tag);
    check({tag, " R10 rd_allow"}, rd_allow, m_rd);
    check({tag, " R10 pg_allow"}, pg_allow, m_pg);
  endtask

  task automatic power_on();
    @(negedge clk);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    m_rd = s_rd; m_pg = s_pg;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F5A));
    s_rd = '1; s_pg = '1; m_rd = '1; m_pg = '1;
    repeat (3) @(negedge clk);
    factory_n = 1'b1; warm_rst_n = 1'b1;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {31'd0, rsp_valid}, 32'd0);
    rd("R1 rd reg", 12'h130, 32'hFFFF_FFFF);
    rd("R1 pg reg", 12'h400, 32'hFFFF_FFFF);
    outs("R1");

    wr(12'h130, ~32'h8);
    rd("R3 alias 0x200", 12'h200, ~32'h8);
    rd("R4 pg untouched", 12'h134, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFF);
    rd("R2 ones cannot set", 12'h130, ~32'h8);
    wr(12'h400, ~32'h80);
    rd("R3 alias 0x134", 12'h134, ~32'h80);
    rd("R4 rd untouched", 12'h200, ~32'h8);
    outs("R2");

    @(negedge clk); bus_rd = 1'b1; bus_addr = 12'h130;
    @(negedge clk); bus_rd = 1'b0; warm_rst_n = 1'b0;
    @(negedge clk);
    check("R8 warm drops rsp", {31'd0, rsp_valid}, 32'd0);
    warm_rst_n = 1'b1;
    rd("R8 rd kept", 12'h130, ~32'h8);
    rd("R8 pg kept", 12'h400, ~32'h80);

    wr(12'h0F0, {16'h5A16, 16'h0003});
    power_on();
    rd("R7 bad key rd", 12'h130, 32'hFFFF_FFFF);
    rd("R6 pg restored", 12'h134, 32'hFFFF_FFFF);
    rd("R9 commit reads zero", 12'h0F0, 32'h0);
    rd("R9 unmapped zero", 12'h004, 32'h0);

    wr(12'h130, ~32'h0000_0105);
    wr(12'h134, ~32'h0001_0000);
    wr(12'h0F0, {16'h5A17, 16'h0001});
    power_on();
    rd("R5 committed rd", 12'h200, ~32'h0000_0105);
    rd("R6 uncommitted pg", 12'h400, 32'hFFFF_FFFF);
    outs("R5");

    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wr(12'h130, sparse());
        1: wr(12'h200, sparse());
        2: wr(12'h134, sparse());
        3: wr(12'h400, sparse());
        4: wr(12'h0F0, {16'h5A17, 14'd0, 2'($urandom_range(0, 3))});
        5: wr(12'h0F0, {16'($urandom_range(0, 16'h5A16)), 16'h0003});
        6: power_on();
        7: rd("R3 rand rd", ($urandom_range(0, 1) != 0) ? 12'h130 : 12'h200, m_rd);
        8: rd("R3 rand pg", ($urandom_range(0, 1) != 0) ? 12'h134 : 12'h400, m_pg);
        default: outs("R2 rand");
      endcase
    end
    power_on();
    rd("R5 final rd", 12'h130, s_rd);
    rd("R5 final pg", 12'h134, s_pg);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule